// File: doc/BRIEF.md
# Multi-Channel Memory Request Scheduler

This block shares one synchronous SRAM port among several data channels. It walks a programmable list of service slots. Each slot names one channel. A normal slot spends one cycle testing whether its channel is requesting. When the channel is requesting, the access follows in the next cycle. A slot can be marked as implied by the slot before it. If that earlier slot made an access in the current round, the implied slot skips its test and issues its access at once. This saves one cycle for each channel that is known to request together with its neighbour.

Every access drives the SRAM enable, write enable, address and write data from the selected channel. The channel sees a one-cycle acknowledge in the same cycle. Read data returns a fixed number of cycles later, together with a valid strobe for the channel that issued the read. The scheduler tags each read with its channel so that data can be returned to the correct channel.

In pipelined mode the walk continues directly after a read. Several reads can then be in flight at once. In non-pipelined mode the walk halts after each read until its data is back. Writes never cause a halt.

Top module: `mem_req_sched`

## Requirements
- R1: While reset is asserted, no access is made, no acknowledge is raised and no read-valid strobe is raised. The first cycle after reset is the test cycle of slot 0.
- R2: Slots are served in index order 0 to `cfg_len`-1, and the walk then wraps to slot 0. Each slot holds a channel number in `cfg_order[slot*CW +: CW]`. A channel that appears in no slot below `cfg_len` is never served.
- R3: A slot that is not implied spends one test cycle. If the channel's `ch_req` bit is 1 in that cycle, the access is made in the next cycle. If the bit is 0, the walk moves to the next slot and no access is made.
- R4: Bit i of `cfg_implied` marks slot i as implied (bit 0 is ignored). If the previous slot made an access in this round, an implied slot makes its access in its first cycle, with no test cycle and whatever its `ch_req` is. If the previous slot made no access, the implied slot is tested as in R3.
- R5: In an access cycle, `mem_en` is 1 and `mem_we` equals the channel's `ch_we` bit. `mem_addr` and `mem_wdata` carry that channel's address and data, and `ch_ack` is one-hot on that channel. In every other cycle `mem_en` and `ch_ack` are 0.
- R6: A read made in cycle t raises the issuing channel's `ch_rvalid` bit in cycle t+RD_LAT, with the SRAM data on `ch_rdata`.
- R7: With `cfg_pipe`=1, the next slot starts in the cycle after any access.
- R8: With `cfg_pipe`=0, a read is followed by RD_LAT idle cycles before the next slot starts. A write is followed by the next slot at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_order | input | MAXLEN*CW | Channel number for each service slot |
| cfg_len | input | LW | Number of slots in a round (at least 1) |
| cfg_implied | input | MAXLEN | Per-slot implied flag |
| cfg_pipe | input | 1 | 1 selects pipelined access mode |
| ch_req | input | NCH | Per-channel access request |
| ch_we | input | NCH | Per-channel write (1) or read (0) |
| ch_addr | input | NCH*AW | Per-channel address |
| ch_wdata | input | NCH*DW | Per-channel write data |
| ch_ack | output | NCH | One-cycle acknowledge of the access |
| ch_rvalid | output | NCH | Read data valid for the issuing channel |
| ch_rdata | output | DW | Returned read data |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, RD_LAT cycles after the read |

## Verification
The bench sweeps three slot orders (one of them leaves a channel out), every implied mask, both access modes, every request subset and three read/write mixes. For each combination it builds the expected cycle timeline from the slot rules. A design that tested implied slots anyway would run every acknowledge one cycle late. A design that trusted the implied flag after a silent predecessor would acknowledge channels that never asked. Honouring bit 0 of the mask would make the first slot skip its test.

A missing or wrong read wait in non-pipelined mode moves every later acknowledge. A mis-tagged read pipeline strobes the wrong channel, or strobes at the wrong cycle. Serving a channel that is left out of the order shows up as a stray acknowledge or a changed memory word.

// File: rtl/mem_req_sched.sv
module mem_req_sched #(
  parameter int NCH    = 4,
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int RD_LAT = 2,
  parameter int MAXLEN = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int WW = $clog2(RD_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAXLEN*CW-1:0] cfg_order,
  input  logic [LW-1:0]     cfg_len,
  input  logic [MAXLEN-1:0] cfg_implied,
  input  logic              cfg_pipe,
  input  logic [NCH-1:0]    ch_req,
  input  logic [NCH-1:0]    ch_we,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic [NCH*DW-1:0] ch_wdata,
  output logic [NCH-1:0]    ch_ack,
  output logic [NCH-1:0]    ch_rvalid,
  output logic [DW-1:0]     ch_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);

  typedef enum logic [1:0] {S_TEST, S_ISSUE, S_WAIT} st_t;

  st_t           st, st_n;
  logic [PW-1:0] ptr, ptr_n, nptr;
  logic [WW-1:0] wcnt, wcnt_n;
  logic [CW-1:0] cur;
  logic          cur_we, issue, rd_issue, last, nxt_imp;

  logic [RD_LAT-1:0] tv;
  logic [CW-1:0]     tc [RD_LAT];

  assign cur      = cfg_order[ptr*CW +: CW];
  assign cur_we   = ch_we[cur];
  assign issue    = (st == S_ISSUE);
  assign rd_issue = issue && !cur_we;
  assign last     = (int'(ptr) + 1 >= int'(cfg_len));
  assign nptr     = last ? '0 : ptr + 1'b1;
  assign nxt_imp  = (nptr != '0) && cfg_implied[nptr];

  assign mem_en    = issue;
  assign mem_we    = issue && cur_we;
  assign mem_addr  = ch_addr[cur*AW +: AW];
  assign mem_wdata = ch_wdata[cur*DW +: DW];
  assign ch_ack    = issue ? (NCH'(1) << cur) : '0;
  assign ch_rvalid = tv[RD_LAT-1] ? (NCH'(1) << tc[RD_LAT-1]) : '0;
  assign ch_rdata  = mem_rdata;

  always_comb begin
    st_n   = st;
    ptr_n  = ptr;
    wcnt_n = wcnt;
    unique case (st)
      S_TEST:
        if (ch_req[cur]) st_n = S_ISSUE;
        else begin
          ptr_n = nptr;
          st_n  = S_TEST;
        end
      S_ISSUE:
        if (!cur_we && !cfg_pipe) begin
          st_n   = S_WAIT;
          wcnt_n = WW'(RD_LAT - 1);
        end else begin
          ptr_n = nptr;
          st_n  = nxt_imp ? S_ISSUE : S_TEST;
        end
      S_WAIT:
        if (wcnt == '0) begin
          ptr_n = nptr;
          st_n  = nxt_imp ? S_ISSUE : S_TEST;
        end else wcnt_n = wcnt - 1'b1;
      default: st_n = S_TEST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_TEST;
      ptr  <= '0;
      wcnt <= '0;
    end else begin
      st   <= st_n;
      ptr  <= ptr_n;
      wcnt <= wcnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv <= '0;
      for (int i = 0; i < RD_LAT; i++) tc[i] <= '0;
    end else begin
      tv[0] <= rd_issue;
      tc[0] <= cur;
      for (int i = 1; i < RD_LAT; i++) begin
        tv[i] <= tv[i-1];
        tc[i] <= tc[i-1];
      end
    end
  end

  // R3: a silent, tested slot leads to no access in the following cycle
  a_r3_silent_test_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TEST && !ch_req[cur]) |=> !mem_en);

  // R8: in non-pipelined mode a read is never followed directly by an access
  a_r8_read_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && !cfg_pipe) |=> !mem_en);

  // R8: in non-pipelined mode at most one read is in flight
  a_r8_single_read_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pipe |-> ($countones(tv) <= 1));

  // R7: pipelined mode never enters the wait state
  a_r7_pipe_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pipe && issue) |=> (st != S_WAIT));

  // R6: read returns strobe one channel at a time
  a_r6_rvalid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rvalid));

endmodule

// File: tb/tb_mem_req_sched.sv
module tb_mem_req_sched;
  localparam int NCH = 4, AW = 8, DW = 16, RD_LAT = 2, MAXLEN = 8;
  localparam int CW = 2, LW = 4;

  logic clk = 0, rst_n = 0;
  logic [MAXLEN*CW-1:0] cfg_order = '0;
  logic [LW-1:0] cfg_len = 4;
  logic [MAXLEN-1:0] cfg_implied = '0;
  logic cfg_pipe = 0;
  logic [NCH-1:0] ch_req = '0, ch_we = '0;
  logic [NCH*AW-1:0] ch_addr = '0;
  logic [NCH*DW-1:0] ch_wdata = '0;
  logic [NCH-1:0] ch_ack, ch_rvalid;
  logic [DW-1:0] ch_rdata, mem_wdata, mem_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mem_req_sched #(.NCH(NCH), .AW(AW), .DW(DW), .RD_LAT(RD_LAT), .MAXLEN(MAXLEN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .cfg_len(cfg_len),
    .cfg_implied(cfg_implied), .cfg_pipe(cfg_pipe), .ch_req(ch_req), .ch_we(ch_we),
    .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_ack(ch_ack), .ch_rvalid(ch_rvalid),
    .ch_rdata(ch_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [DW-1:0] mem [256];
  logic [DW-1:0] rp [RD_LAT];
  assign mem_rdata = rp[RD_LAT-1];

  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    rp[0] <= (mem_en && !mem_we) ? mem[mem_addr] : '0;
    for (int i = 1; i < RD_LAT; i++) rp[i] <= rp[i-1];
  end

  function automatic logic [DW-1:0] init_val(int a);
    return {a[7:0], a[7:0] ^ 8'h5A};
  endfunction

  function automatic logic [DW-1:0] wval(int c);
    return 16'hA500 + 16'(c * 17);
  endfunction

  function automatic int ord_of(int o, int i);
    int t0 [4] = '{0, 1, 2, 3};
    int t1 [4] = '{3, 1, 0, 2};
    int t2 [4] = '{2, 0, 3, 0};
    case (o)
      0: return t0[i];
      1: return t1[i];
      default: return t2[i];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [NCH-1:0] exp_ack [64];
  logic [NCH-1:0] exp_rv  [64];
  logic [NCH-1:0] wr_done;

  task automatic trial(input int o, input logic [MAXLEN-1:0] mask, input bit pipe,
                       input logic [NCH-1:0] reqs, input logic [NCH-1:0] wes);
    int len, t, c;
    bit prev, imp;
    len = (o == 2) ? 3 : 4;
    for (int a = 0; a < 256; a++) mem[a] = init_val(a);
    cfg_order = '0;
    for (int i = 0; i < len; i++) cfg_order[i*CW +: CW] = CW'(ord_of(o, i));
    cfg_len = LW'(len);
    cfg_implied = mask;
    cfg_pipe = pipe;
    ch_we = wes;
    for (int k = 0; k < NCH; k++) begin
      ch_addr[k*AW +: AW] = wes[k] ? AW'(8'h80 + k) : AW'(8'h40 + k);
      ch_wdata[k*DW +: DW] = wval(k);
    end
    ch_req = reqs;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    #1;
    chk(ch_ack == '0 && !mem_en && ch_rvalid == '0, "R1", "quiet in reset",
        {ch_ack, ch_rvalid, 3'b0, mem_en}, 0);
    for (int k = 0; k < 64; k++) begin exp_ack[k] = '0; exp_rv[k] = '0; end
    wr_done = '0;
    t = 0; prev = 0;
    for (int i = 0; i < len; i++) begin
      c = ord_of(o, i);
      imp = (i > 0) && mask[i] && prev;
      if (imp || reqs[c]) begin
        if (!imp) t++;
        exp_ack[t][c] = 1'b1;
        if (wes[c]) wr_done[c] = 1'b1;
        else exp_rv[t + RD_LAT][c] = 1'b1;
        t++;
        if (!wes[c] && !pipe) t += RD_LAT;
        prev = 1;
      end else begin
        t++;
        prev = 0;
      end
    end
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k <= t + RD_LAT; k++) begin
      #1;
      chk(ch_ack == exp_ack[k], "R2/R3/R4/R7/R8", $sformatf("ack timeline cycle %0d", k),
          32'(ch_ack), 32'(exp_ack[k]));
      chk(mem_en == (exp_ack[k] != '0), "R5", $sformatf("mem_en cycle %0d", k),
          32'(mem_en), 32'(exp_ack[k] != '0));
      if (exp_ack[k] != '0) begin
        for (int q = 0; q < NCH; q++) if (exp_ack[k][q]) begin
          chk(mem_we == wes[q], "R5", "mem_we", 32'(mem_we), 32'(wes[q]));
          chk(mem_addr == (wes[q] ? AW'(8'h80 + q) : AW'(8'h40 + q)), "R5", "mem_addr",
              32'(mem_addr), 32'(wes[q] ? 8'h80 + q : 8'h40 + q));
          if (wes[q]) chk(mem_wdata == wval(q), "R5", "mem_wdata", 32'(mem_wdata), 32'(wval(q)));
        end
      end
      chk(ch_rvalid == exp_rv[k], "R6", $sformatf("rvalid cycle %0d", k),
          32'(ch_rvalid), 32'(exp_rv[k]));
      for (int q = 0; q < NCH; q++) if (exp_rv[k][q])
        chk(ch_rdata == init_val(8'h40 + q), "R6", "rdata", 32'(ch_rdata), 32'(init_val(8'h40 + q)));
      ch_req = ch_req & ~ch_ack;
      @(negedge clk);
    end
    for (int q = 0; q < NCH; q++) begin
      if (wr_done[q])
        chk(mem[8'h80 + q] == wval(q), "R5", "written word", 32'(mem[8'h80 + q]), 32'(wval(q)));
      else
        chk(mem[8'h80 + q] == init_val(8'h80 + q), "R2", "untouched word",
            32'(mem[8'h80 + q]), 32'(init_val(8'h80 + q)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NCH-1:0] wpat [3] = '{4'b0000, 4'b1010, 4'b1111};
    for (int o = 0; o < 3; o++)
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 2; p++)
          for (int r = 0; r < 16; r++)
            for (int w = 0; w < 3; w++)
              trial(o, MAXLEN'({m[2:0], m[0]}), p[0], NCH'(r), wpat[w]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule